// File: doc/BRIEF.md
# Triangle-Carrier Unipolar PWM Modulator

This block produces the four gate commands of one single-phase H-bridge cell by unipolar pulse-width modulation. An internal up/down counter generates a triangle carrier whose top and bottom limits, rising step, falling step and start value are all inputs that may change while the block runs. The step sizes set the carrier slope, and with it the PWM resolution. The start value, loaded while reset is held, fixes where the carrier begins and so sets its phase against other cells.

Each bridge leg has its own signed reference. Leg A compares its reference against the carrier; leg B compares the negated form of its own reference, so that with equal references the two legs switch in opposite senses and the bridge output takes three levels. For each leg the upper gate is on while the (effective) reference is strictly greater than the carrier, and the lower gate is always the opposite of the upper one. The gate bits are registered.

Top module: `pwm_unipolar_mod`

## Requirements
- R1: While `rst` is high at a clock edge, the carrier is loaded from `phase_init` and the count direction becomes rising; the carrier output shows this value after that edge.
- R2: A `phase_init` above `lim_top` loads `lim_top`, and one below `lim_bot` loads `lim_bot`.
- R3: While rising and not reaching `lim_top`, each clock edge adds `step_rise` to the carrier.
- R4: While falling and not reaching `lim_bot`, each clock edge subtracts `step_fall` from the carrier.
- R5: While rising, if carrier plus `step_rise` is greater than or equal to `lim_top`, the carrier becomes exactly `lim_top` and the direction turns to falling.
- R6: While falling, if carrier minus `step_fall` is less than or equal to `lim_bot`, the carrier becomes exactly `lim_bot` and the direction turns to rising.
- R7: `gate[0]` (leg A upper) becomes 1 on the clock edge after a cycle in which `ref_leg_a` is strictly greater than the carrier output, and 0 otherwise.
- R8: `gate[2]` (leg B upper) becomes 1 on the clock edge after a cycle in which the negation of `ref_leg_b`, taken without overflow, is strictly greater than the carrier output, and 0 otherwise.
- R9: `gate[1]` (leg A lower) is always the inverse of `gate[0]` and `gate[3]` (leg B lower) the inverse of `gate[2]`; reset leaves the upper gates 0 and the lower gates 1 (gate = 4'b1010).
- R10: Changes of limits and step sizes take effect on the next clock edge without a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the start value |
| lim_top | input | CW | Signed carrier upper limit |
| lim_bot | input | CW | Signed carrier lower limit |
| step_rise | input | CW | Unsigned increment while rising |
| step_fall | input | CW | Unsigned decrement while falling |
| phase_init | input | CW | Signed carrier start value loaded on reset |
| ref_leg_a | input | CW | Signed reference of leg A |
| ref_leg_b | input | CW | Signed reference of leg B (negated internally) |
| gate | output | 4 | {B lower, B upper, A lower, A upper} |
| carrier | output | CW | Signed carrier value |

## Verification
On every cycle the assertions check the turn-around at both limits (exact clamp plus direction change), that each upper gate equals the previous cycle's comparison, and that each lower gate is the inverse of its upper gate. The exact start value after reset, clamping of an out-of-range start value, the step arithmetic between the limits, the saturation-free negation of the most negative leg B reference and the effect of limits changed mid-run are shown by the bench scenarios, where a behavioural model is compared against the carrier and all four gates every clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } count_dir_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } leg_gate_t;

    localparam int NUM_LEGS  = 2;
    localparam int GATE_BITS = 2 * NUM_LEGS;

endpackage

// File: rtl/pwm_carrier_gen.sv
module pwm_carrier_gen
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [CW-1:0] lim_top,
    input  logic signed [CW-1:0] lim_bot,
    input  logic        [CW-1:0] step_rise,
    input  logic        [CW-1:0] step_fall,
    input  logic signed [CW-1:0] phase_init,
    output logic signed [CW-1:0] carrier
);

    localparam int EW = CW + 2;

    count_dir_e dir_q;

    logic signed [EW-1:0] ext_c;
    logic signed [EW-1:0] ext_top;
    logic signed [EW-1:0] ext_bot;
    logic signed [EW-1:0] rise_sum;
    logic signed [EW-1:0] fall_diff;
    logic                 hit_top;
    logic                 hit_bot;
    logic signed [CW-1:0] start_val;

    always_comb begin
        ext_c     = EW'(carrier);
        ext_top   = EW'(lim_top);
        ext_bot   = EW'(lim_bot);
        rise_sum  = ext_c + $signed({2'b00, step_rise});
        fall_diff = ext_c - $signed({2'b00, step_fall});
        hit_top   = (rise_sum >= ext_top);
        hit_bot   = (fall_diff <= ext_bot);
        if (phase_init > lim_top) begin
            start_val = lim_top;
        end else if (phase_init < lim_bot) begin
            start_val = lim_bot;
        end else begin
            start_val = phase_init;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carrier <= start_val;
            dir_q   <= DIR_UP;
        end else begin
            case (dir_q)
                DIR_UP: begin
                    if (hit_top) begin
                        carrier <= lim_top;
                        dir_q   <= DIR_DOWN;
                    end else begin
                        carrier <= rise_sum[CW-1:0];
                    end
                end
                default: begin
                    if (hit_bot) begin
                        carrier <= lim_bot;
                        dir_q   <= DIR_UP;
                    end else begin
                        carrier <= fall_diff[CW-1:0];
                    end
                end
            endcase
        end
    end

    assert_top_turn_R5: assert property (@(posedge clk) disable iff (rst)
        (dir_q == DIR_UP && hit_top) |=> (carrier == $past(lim_top) && dir_q == DIR_DOWN));

    assert_bot_turn_R6: assert property (@(posedge clk) disable iff (rst)
        (dir_q == DIR_DOWN && hit_bot) |=> (carrier == $past(lim_bot) && dir_q == DIR_UP));

endmodule

// File: rtl/pwm_leg_cmp.sv
module pwm_leg_cmp
    import pwm_pkg::*;
#(
    parameter int CW     = 16,
    parameter bit NEGATE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [CW-1:0] ref_in,
    input  logic signed [CW-1:0] carrier,
    output leg_gate_t            gate
);

    logic signed [CW:0] ref_ext;
    logic signed [CW:0] ref_eff;
    logic signed [CW:0] car_ext;
    logic               above;

    always_comb begin
        ref_ext = (CW+1)'(ref_in);
        car_ext = (CW+1)'(carrier);
    end

    generate
        if (NEGATE) begin : g_neg
            always_comb ref_eff = -ref_ext;
        end else begin : g_pos
            always_comb ref_eff = ref_ext;
        end
    endgenerate

    always_comb above = (ref_eff > car_ext);

    always_ff @(posedge clk) begin
        if (rst) begin
            gate.hi <= 1'b0;
            gate.lo <= 1'b1;
        end else begin
            gate.hi <= above;
            gate.lo <= ~above;
        end
    end

    // R7 for leg A instance, R8 for leg B instance
    assert_gate_follows_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (gate.hi == ($past(ref_eff) > $past(car_ext))));

    assert_lo_inverse_R9: assert property (@(posedge clk) disable iff (rst)
        gate.lo == ~gate.hi);

endmodule

// File: rtl/pwm_unipolar_mod.sv
module pwm_unipolar_mod
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [CW-1:0] lim_top,
    input  logic signed [CW-1:0] lim_bot,
    input  logic        [CW-1:0] step_rise,
    input  logic        [CW-1:0] step_fall,
    input  logic signed [CW-1:0] phase_init,
    input  logic signed [CW-1:0] ref_leg_a,
    input  logic signed [CW-1:0] ref_leg_b,
    output logic        [3:0]    gate,
    output logic signed [CW-1:0] carrier
);

    logic signed [CW-1:0] leg_ref [NUM_LEGS];
    leg_gate_t            leg_gate [NUM_LEGS];

    assign leg_ref[0] = ref_leg_a;
    assign leg_ref[1] = ref_leg_b;

    pwm_carrier_gen #(.CW(CW)) u_carrier (
        .clk        (clk),
        .rst        (rst),
        .lim_top    (lim_top),
        .lim_bot    (lim_bot),
        .step_rise  (step_rise),
        .step_fall  (step_fall),
        .phase_init (phase_init),
        .carrier    (carrier)
    );

    generate
        for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
            pwm_leg_cmp #(.CW(CW), .NEGATE(g == 1)) u_leg (
                .clk     (clk),
                .rst     (rst),
                .ref_in  (leg_ref[g]),
                .carrier (carrier),
                .gate    (leg_gate[g])
            );
            assign gate[2*g]   = leg_gate[g].hi;
            assign gate[2*g+1] = leg_gate[g].lo;
        end
    endgenerate

endmodule

// File: tb/pwm_unipolar_mod_tb.sv
module pwm_unipolar_mod_tb;

    localparam int CW = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [CW-1:0] lim_top = 16'sd100;
    logic signed [CW-1:0] lim_bot = -16'sd100;
    logic        [CW-1:0] step_rise = 16'd7;
    logic        [CW-1:0] step_fall = 16'd5;
    logic signed [CW-1:0] phase_init = 16'sd95;
    logic signed [CW-1:0] ref_leg_a = 16'sd30;
    logic signed [CW-1:0] ref_leg_b = 16'sd30;
    logic        [3:0]    gate;
    logic signed [CW-1:0] carrier;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int  m_car = 0;
    bit  m_down = 0;
    bit  m_g[4] = '{0, 1, 0, 1};
    bit  m_valid = 0;

    pwm_unipolar_mod #(.CW(CW)) u_dut (
        .clk(clk), .rst(rst), .lim_top(lim_top), .lim_bot(lim_bot),
        .step_rise(step_rise), .step_fall(step_fall), .phase_init(phase_init),
        .ref_leg_a(ref_leg_a), .ref_leg_b(ref_leg_b),
        .gate(gate), .carrier(carrier)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        int top, bot, c, ga, gb;
        top = int'(lim_top);
        bot = int'(lim_bot);
        if (rst) begin
            c = int'(phase_init);
            if (c > top) c = top;
            else if (c < bot) c = bot;
            m_car  = c;
            m_down = 0;
            m_g    = '{0, 1, 0, 1};
        end else begin
            ga = (int'(ref_leg_a) > m_car) ? 1 : 0;
            gb = ((-int'(ref_leg_b)) > m_car) ? 1 : 0;
            m_g[0] = ga[0]; m_g[1] = !ga[0];
            m_g[2] = gb[0]; m_g[3] = !gb[0];
            if (!m_down) begin
                c = m_car + int'(step_rise);
                if (c >= top) begin m_car = top; m_down = 1; end
                else m_car = c;
            end else begin
                c = m_car - int'(step_fall);
                if (c <= bot) begin m_car = bot; m_down = 0; end
                else m_car = c;
            end
        end
        m_valid = 1;
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (m_valid) begin
            chk(int'(carrier) == m_car, "R3/R4/R5/R6 carrier vs model", int'(carrier), m_car);
            chk(gate[0] == m_g[0], "R7 leg A upper vs model", int'(gate[0]), int'(m_g[0]));
            chk(gate[2] == m_g[2], "R8 leg B upper vs model", int'(gate[2]), int'(m_g[2]));
            chk(gate[1] == m_g[1] && gate[3] == m_g[3], "R9 lower gates vs model",
                int'(gate), int'({m_g[3], m_g[2], m_g[1], m_g[0]}));
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // reset with in-range start value
        cyc(2);
        chk(carrier == 16'sd95, "R1 start value loaded", int'(carrier), 95);
        chk(gate == 4'b1010, "R9 reset gate pattern", int'(gate), 10);
        rst = 1'b0;
        cyc(1);
        chk(carrier == 16'sd100, "R5 clamp at top", int'(carrier), 100);
        cyc(1);
        chk(carrier == 16'sd95, "R4 falling step", int'(carrier), 95);
        cyc(200);

        // rising step from a low start
        rst = 1'b1; phase_init = -16'sd98;
        cyc(1);
        rst = 1'b0;
        cyc(1);
        chk(carrier == -16'sd91, "R3 rising step after reset", int'(carrier), -91);

        // out-of-range start values
        rst = 1'b1; phase_init = 16'sd500;
        cyc(1);
        chk(carrier == 16'sd100, "R2 start above top clamped", int'(carrier), 100);
        phase_init = -16'sd500;
        cyc(1);
        chk(carrier == -16'sd100, "R2 start below bottom clamped", int'(carrier), -100);

        // bottom turn with asymmetric steps
        lim_top = -16'sd90; step_rise = 16'd20; step_fall = 16'd3;
        cyc(1);
        rst = 1'b0;
        cyc(1);
        chk(carrier == -16'sd90, "R5 overshoot clamps to top", int'(carrier), -90);
        cyc(4);
        chk(carrier == -16'sd100, "R6 clamp at bottom", int'(carrier), -100);
        cyc(1);
        chk(carrier == -16'sd90, "R6 turned to rising", int'(carrier), -90);

        // run-time limit and step changes
        lim_top = 16'sd1000; lim_bot = -16'sd1000; step_rise = 16'd13; step_fall = 16'd29;
        cyc(300);
        lim_top = 16'sd40; step_rise = 16'd1;
        cyc(400);
        chk(carrier <= 16'sd40 && carrier >= -16'sd1000, "R10 new top respected",
            int'(carrier), 40);
        step_rise = 16'd3000; step_fall = 16'd3000;
        cyc(50);

        // reference extremes
        lim_top = 16'sd100; lim_bot = -16'sd100; step_rise = 16'd7; step_fall = 16'd5;
        ref_leg_a = 16'sd32767; ref_leg_b = -16'sd32768;
        cyc(3);
        chk(gate[0] == 1'b1 && gate[1] == 1'b0, "R7 max ref keeps A upper on", int'(gate), 1);
        chk(gate[2] == 1'b1 && gate[3] == 1'b0, "R8 most negative ref_b drives B upper", int'(gate), 4);
        ref_leg_a = -16'sd32768; ref_leg_b = 16'sd32767;
        cyc(2);
        chk(gate == 4'b1010, "R7 R8 min effective refs keep uppers off", int'(gate), 10);

        // mid references over the full carrier sweep
        ref_leg_a = 16'sd20; ref_leg_b = -16'sd45;
        cyc(300);
        ref_leg_a = 16'sd100; ref_leg_b = 16'sd100;
        cyc(100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule